// File: doc/BRIEF.md
# Indirect Flash Access Bridge

This block gives a processor byte-wide access to a serial flash through a small window of five registers: four address bytes and one data byte. In normal mode a read of the data byte becomes a complete flash read transaction on the SPI pins. The bridge sends the read command and the address, captures one byte and returns it.

Follow mode is selected by a particular value in the top address byte. In this mode the bridge stops building transactions. The value held in address byte 1 then decides the chip-select level, and each access to the data byte moves one raw byte over the SPI link. Software uses this to issue any flash command (write enable, page program, erase, status polling) one byte at a time.

An SPI bit engine is built in. SCK comes from the system clock through a parameterised divider. While a byte moves, `busy` is high and the register port takes no new access.

Top module: `flash_window_bridge`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0 and all four address bytes read back as 0x00.
- R2: Address byte 0 at offset 0x3B, byte 1 at 0x3C, byte 2 at 0x3D and byte 3 at 0x3E each read back the last value written. A register read returns its value on `reg_rdata` one cycle after the strobe.
- R3: Normal-mode read. When the low nibble of byte 3 is not 0xF and bit 6 of byte 3 is 1, a read of offset 0x3F does the following:
  - it drives CS low;
  - it sends 0x03, then byte 2, byte 1 and byte 0, each MSB first;
  - it clocks in one more byte and returns that byte on `reg_rdata`;
  - it then raises CS.
- R4: In normal mode with bit 6 of byte 3 at 0, a read of 0x3F returns 0xFF. It makes no SCK edge and no CS edge.
- R5: Follow mode is active while byte 3 bits [3:0] equal 0xF. In follow mode with byte 1 = 0xFD, a write to 0x3F drives CS low and shifts the written byte out MSB first. CS stays low afterwards.
- R6: In follow mode with byte 1 = 0xFE, any write to 0x3F drives CS high and makes no SCK edge.
- R7: In follow mode with byte 1 = 0xFD, a read of 0x3F clocks in one byte from MISO and returns it. CS stays low.
- R8: Writing byte 3 with a low nibble other than 0xF leaves follow mode. Later reads of 0x3F are normal-mode reads built from the current address bytes.
- R9: `busy` is 1 from the cycle after a transfer starts until the byte (or the whole normal read) ends. Register strobes seen while `busy` is 1 are ignored.
- R10: SPI mode 0 applies:
  - SCK is low whenever CS is high or the bridge is idle;
  - MOSI is stable while SCK is high;
  - each SCK half period lasts HALF_DIV system clocks.
- R11: A write to 0x3F in normal mode has no effect on the SPI pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | 8 | Read data, valid once `busy` is low after the read |
| busy | output | 1 | Transfer in progress; the register port is stalled |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |

## Verification
The assertions check the pin-level rules on every cycle:
- SCK stays low while CS is high or the bridge is idle;
- MOSI holds still during the SCK high phase;
- CS falls only as a transfer starts;
- CS rises only when the bridge is idle.

Only the bench scenarios, run against a behavioural flash model, can show the register-level results:
- the byte order of the read header;
- the data returned in each mode;
- that follow mode is entered and left correctly;
- that strobes during a transfer, and data writes in normal mode, are ignored.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    localparam int BYTE_W = 8;

    // register window offsets; software decodes these
    localparam logic [7:0] OFF_ADR0 = 8'h3B;
    localparam logic [7:0] OFF_ADR1 = 8'h3C;
    localparam logic [7:0] OFF_ADR2 = 8'h3D;
    localparam logic [7:0] OFF_ADR3 = 8'h3E;
    localparam logic [7:0] OFF_DATA = 8'h3F;

    localparam logic [3:0] FOLLOW_NIBBLE = 4'hF;
    localparam int         TARGET_BIT    = 6;
    localparam logic [7:0] KEY_CS_HIGH   = 8'hFE;
    localparam logic [7:0] KEY_CS_LOW    = 8'hFD;
    localparam logic [7:0] CMD_READ      = 8'h03;

    // normal read: command, three address bytes, one data byte
    localparam int         NRD_BYTES = 5;
    localparam logic [2:0] NRD_LAST  = 3'(NRD_BYTES - 1);

    typedef enum logic {ST_IDLE, ST_XFER} br_state_e;
    typedef enum logic [1:0] {K_FWR, K_FRD, K_NRD} xfer_kind_e;

    typedef struct packed {
        logic             act;
        logic             sck;
        logic [2:0]       bitn;
        logic [BYTE_W-1:0] tsh;
        logic [BYTE_W-1:0] rsh;
        logic             done;
    } spi_regs_t;

    typedef struct packed {
        br_state_e              st;
        xfer_kind_e             kind;
        logic [2:0]             seq;
        logic [3:0][BYTE_W-1:0] adr;
        logic                   cs_n;
        logic [BYTE_W-1:0]      rdata;
    } br_regs_t;

endpackage

// File: rtl/fwb_tick.sv
module fwb_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fwb_spi_byte.sv
module fwb_spi_byte
    import fwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              active,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sck,
    output logic              mosi
);
    spi_regs_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.act) begin
            if (start) begin
                d.act  = 1'b1;
                d.sck  = 1'b0;
                d.bitn = '0;
                d.tsh  = tx_byte;
            end
        end else if (tick) begin
            if (!q.sck) begin
                // rising edge: sample the line
                d.sck = 1'b1;
                d.rsh = {q.rsh[BYTE_W-2:0], miso};
            end else begin
                // falling edge: present the next bit or finish
                d.sck = 1'b0;
                if (q.bitn == 3'(BYTE_W - 1)) begin
                    d.act  = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.tsh  = {q.tsh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active  = q.act;
    assign done    = q.done;
    assign rx_byte = q.rsh;
    assign sck     = q.sck;
    assign mosi    = q.tsh[BYTE_W-1];
endmodule

// File: rtl/flash_window_bridge.sv
module flash_window_bridge
    import fwb_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_wr,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata,
    output logic       busy,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    br_regs_t          d, q;
    logic              eng_start, eng_active, eng_done, eng_tick;
    logic [BYTE_W-1:0] eng_tx, eng_rx;
    logic              follow;

    function automatic logic [BYTE_W-1:0] hdr_byte(input logic [2:0] idx,
                                                    input logic [3:0][BYTE_W-1:0] a);
        case (idx)
            3'd1:    return a[2];
            3'd2:    return a[1];
            3'd3:    return a[0];
            default: return '0;
        endcase
    endfunction

    fwb_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (eng_active),
        .tick (eng_tick)
    );

    fwb_spi_byte i_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .tx_byte(eng_tx),
        .tick   (eng_tick),
        .miso   (spi_miso),
        .active (eng_active),
        .done   (eng_done),
        .rx_byte(eng_rx),
        .sck    (spi_sck),
        .mosi   (spi_mosi)
    );

    assign follow = (q.adr[3][3:0] == FOLLOW_NIBBLE);

    always_comb begin
        d         = q;
        eng_start = 1'b0;
        eng_tx    = '0;
        case (q.st)
            ST_IDLE: begin
                if (reg_wr) begin
                    case (reg_addr)
                        OFF_ADR0: d.adr[0] = reg_wdata;
                        OFF_ADR1: d.adr[1] = reg_wdata;
                        OFF_ADR2: d.adr[2] = reg_wdata;
                        OFF_ADR3: d.adr[3] = reg_wdata;
                        OFF_DATA: begin
                            if (follow && q.adr[1] == KEY_CS_HIGH) begin
                                d.cs_n = 1'b1;
                            end else if (follow && q.adr[1] == KEY_CS_LOW) begin
                                d.cs_n    = 1'b0;
                                d.st      = ST_XFER;
                                d.kind    = K_FWR;
                                eng_start = 1'b1;
                                eng_tx    = reg_wdata;
                            end
                        end
                        default: ;
                    endcase
                end else if (reg_rd) begin
                    case (reg_addr)
                        OFF_ADR0: d.rdata = q.adr[0];
                        OFF_ADR1: d.rdata = q.adr[1];
                        OFF_ADR2: d.rdata = q.adr[2];
                        OFF_ADR3: d.rdata = q.adr[3];
                        OFF_DATA: begin
                            if (follow) begin
                                if (q.adr[1] == KEY_CS_LOW) begin
                                    d.cs_n    = 1'b0;
                                    d.st      = ST_XFER;
                                    d.kind    = K_FRD;
                                    eng_start = 1'b1;
                                end else begin
                                    d.rdata = 8'hFF;
                                end
                            end else if (q.adr[3][TARGET_BIT]) begin
                                d.cs_n    = 1'b0;
                                d.st      = ST_XFER;
                                d.kind    = K_NRD;
                                d.seq     = '0;
                                eng_start = 1'b1;
                                eng_tx    = CMD_READ;
                            end else begin
                                d.rdata = 8'hFF;
                            end
                        end
                        default: d.rdata = '0;
                    endcase
                end
            end
            default: begin
                if (eng_done) begin
                    case (q.kind)
                        K_FWR: d.st = ST_IDLE;
                        K_FRD: begin
                            d.rdata = eng_rx;
                            d.st    = ST_IDLE;
                        end
                        default: begin
                            if (q.seq == NRD_LAST) begin
                                d.rdata = eng_rx;
                                d.cs_n  = 1'b1;
                                d.st    = ST_IDLE;
                            end else begin
                                d.seq     = q.seq + 1'b1;
                                eng_start = 1'b1;
                                eng_tx    = hdr_byte(q.seq + 1'b1, q.adr);
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_FWR;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = q.rdata;
    assign busy      = (q.st != ST_IDLE);
    assign spi_cs_n  = q.cs_n;
endmodule

// File: rtl/fwb_checker.sv
module fwb_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sck,
    input logic cs_n,
    input logic mosi
);
    p_sck_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    p_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !busy);

    p_cs_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (busy && !sck));
endmodule

bind flash_window_bridge fwb_checker i_fwb_checker (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (busy),
    .sck  (spi_sck),
    .cs_n (spi_cs_n),
    .mosi (spi_mosi)
);

// File: tb/test_flash_window_bridge.sv
`timescale 1ns/1ps
module test_flash_window_bridge;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       busy, sck, cs_n, mosi;
    logic       miso = 1'b0;

    int n_chk = 0, n_fail = 0;

    flash_window_bridge #(.HALF_DIV(HALF)) i_flash_window_bridge (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .busy(busy),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    always #10 clk = ~clk;

    // ---------------- flash model ----------------
    function automatic logic [7:0] fmem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    logic [7:0]  log_b [0:255];
    int          nlog = 0;
    int          bitcnt = 0;
    logic [7:0]  ish = '0, cmd = '0, osh = '0;
    logic [23:0] faddr = '0;
    int          sck_rises = 0, cs_falls = 0;
    longint      t_prev = 0, t_last = 0;

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            bitcnt = 0;
        end else begin
            ish = {ish[6:0], mosi};
            bitcnt++;
            if (bitcnt % 8 == 0) begin
                log_b[nlog % 256] = ish;
                nlog++;
                if (bitcnt == 8)  cmd = ish;
                if (bitcnt == 16) faddr[23:16] = ish;
                if (bitcnt == 24) faddr[15:8] = ish;
                if (bitcnt == 32) faddr[7:0] = ish;
            end
        end
    end

    always @(negedge sck) begin
        if (!cs_n) begin
            if (cmd == 8'h03 && bitcnt >= 32 && bitcnt % 8 == 0)
                osh = fmem(faddr + 24'((bitcnt - 32) / 8));
            else
                osh = {osh[6:0], 1'b0};
            miso = osh[7];
        end
    end

    always @(posedge sck) begin
        sck_rises++;
        t_prev = t_last;
        t_last = $time;
    end

    always @(negedge cs_n) cs_falls++;

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_idle();
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        wait_idle();
        v = reg_rdata;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] v;
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sck", sck, 0);
        chk("R1 busy", busy, 0);
        for (int i = 0; i < 4; i++) begin
            reg_read(8'h3B + 8'(i), v);
            chk("R1 adr reset", v, 0);
        end
    endtask

    task automatic t_addr_regs();
        logic [7:0] v;
        reg_write(8'h3B, 8'h11); reg_write(8'h3C, 8'h22);
        reg_write(8'h3D, 8'h33); reg_write(8'h3E, 8'h44);
        reg_read(8'h3B, v); chk("R2 adr0", v, 8'h11);
        reg_read(8'h3C, v); chk("R2 adr1", v, 8'h22);
        reg_read(8'h3D, v); chk("R2 adr2", v, 8'h33);
        reg_read(8'h3E, v); chk("R2 adr3", v, 8'h44);
    endtask

    task automatic t_normal_read(input logic [23:0] a);
        logic [7:0] v;
        int base;
        reg_write(8'h3E, 8'h40);
        reg_write(8'h3D, a[23:16]); reg_write(8'h3C, a[15:8]); reg_write(8'h3B, a[7:0]);
        base = nlog;
        reg_addr = 8'h3F; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R9 busy after start", busy, 1);
        chk("R3 cs low", cs_n, 0);
        // write attempt while busy must be dropped
        reg_addr = 8'h3B; reg_wdata = 8'hAA; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_idle();
        chk("R3 data", reg_rdata, fmem(a));
        chk("R3 cs high after", cs_n, 1);
        chk("R3 cmd byte", log_b[base % 256], 8'h03);
        chk("R3 addr hi", log_b[(base + 1) % 256], a[23:16]);
        chk("R3 addr mid", log_b[(base + 2) % 256], a[15:8]);
        chk("R3 addr lo", log_b[(base + 3) % 256], a[7:0]);
        reg_read(8'h3B, v);
        chk("R9 strobe ignored while busy", v, a[7:0]);
    endtask

    task automatic t_no_target();
        logic [7:0] v;
        int r0, c0;
        reg_write(8'h3E, 8'h00);
        r0 = sck_rises; c0 = cs_falls;
        reg_read(8'h3F, v);
        repeat (4) @(negedge clk);
        chk("R4 data", v, 8'hFF);
        chk("R4 no sck", sck_rises - r0, 0);
        chk("R4 no cs", cs_falls - c0, 0);
    endtask

    task automatic t_normal_write();
        int r0, c0;
        reg_write(8'h3E, 8'h40);
        r0 = sck_rises; c0 = cs_falls;
        reg_write(8'h3F, 8'h77);
        repeat (6) @(negedge clk);
        chk("R11 no sck", sck_rises - r0, 0);
        chk("R11 no cs", cs_falls - c0, 0);
        chk("R11 cs high", cs_n, 1);
    endtask

    task automatic t_follow();
        logic [7:0] v;
        int base, r0;
        reg_write(8'h3E, 8'h4F);
        reg_write(8'h3D, 8'hFF);
        reg_write(8'h3C, 8'hFE);
        reg_write(8'h3B, 8'h00);
        reg_write(8'h3F, 8'h00);
        chk("R6 cs high", cs_n, 1);
        reg_write(8'h3C, 8'hFD);
        base = nlog;
        reg_write(8'h3F, 8'h03);
        chk("R5 cs low after byte", cs_n, 0);
        chk("R10 half period", 32'(t_last - t_prev), 32'(2 * HALF * 20));
        chk("R10 sck idle low", sck, 0);
        reg_write(8'h3F, 8'h00);
        reg_write(8'h3F, 8'h12);
        reg_write(8'h3F, 8'h34);
        chk("R5 byte0", log_b[base % 256], 8'h03);
        chk("R5 byte2", log_b[(base + 2) % 256], 8'h12);
        chk("R5 byte3", log_b[(base + 3) % 256], 8'h34);
        reg_read(8'h3F, v);
        chk("R7 read0", v, fmem(24'h001234));
        chk("R7 cs low", cs_n, 0);
        reg_read(8'h3F, v);
        chk("R7 read1", v, fmem(24'h001235));
        reg_write(8'h3C, 8'hFE);
        r0 = sck_rises;
        reg_write(8'h3F, 8'h00);
        chk("R6 cs forced high", cs_n, 1);
        chk("R6 no sck", sck_rises - r0, 0);
    endtask

    task automatic t_exit();
        logic [7:0] v;
        int base;
        reg_write(8'h3E, 8'h40);
        reg_write(8'h3D, 8'h00);
        base = nlog;
        reg_read(8'h3F, v);
        chk("R8 normal read after exit", v, fmem(24'h00FE00));
        chk("R8 cmd", log_b[base % 256], 8'h03);
        chk("R8 addr mid", log_b[(base + 2) % 256], 8'hFE);
        chk("R8 cs high", cs_n, 1);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_regs();
        t_normal_read(24'h012345);
        t_normal_read(24'h0AFF00);
        t_no_target();
        t_normal_write();
        t_follow();
        t_exit();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule